// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Refresh Scanner

This block keeps a 24-position display of 5x7 dot characters lit by repeatedly loading an external serial-in driver (shift register, latch and high-voltage outputs). For every load it assembles one frame: a gate field with a single active gate for the current position, followed by the 35 anode bits made from that position's five pixel columns. The frame goes out on a serial clock and data pair. A strobe then latches it while the outputs are blanked. The active gate steps one position per load and wraps, so the whole display is rescanned without a break.

Pixel columns live in a single-port memory inside the block, one 7-bit word per column. The host writes columns through a plain write port. Refresh reads use fixed slots near the start of each load. A host write that arrives in a refresh slot waits in a one-entry hold register and is committed in the next free cycle. The serial clock, strobe and blank timing therefore never depend on host traffic. A display-enable input forces blank while it is low.

Top module: `vfd_scan_refresh`

## Requirements
- R1: While reset is asserted, `vfd_sclk`, `vfd_strobe` and `vfd_sdata` are 0 and `vfd_blank` is 1.
- R2: Between two strobe pulses there are exactly NUM_POS + COLS*ROWS (59 by default) rising edges of `vfd_sclk`, and `vfd_sclk` is low while `vfd_strobe` is high.
- R3: The first NUM_POS bits of a frame, in shift order, form the gate field. Bit k drives gate k, and exactly one of these bits is 1: the one for the position of that load.
- R4: The first load after reset addresses position 0. Each later load addresses the next position, and the count wraps from NUM_POS-1 back to 0.
- R5: Frame bit NUM_POS + col*ROWS + row (shift order, col 0..COLS-1, row 0..ROWS-1) equals bit `row` of the memory word at address pos*COLS + col.
- R6: `vfd_strobe` goes high once per load, after the last data bit, for DIV cycles. `vfd_blank` rises in the same cycle as the strobe and stays high for 2*DIV cycles. While display enable is high, blank is low at all other times.
- R7: Consecutive strobe rises are exactly GAP + 2*DIV*(NUM_POS + COLS*ROWS + 1) cycles apart, whatever the host does.
- R8: Every host write takes effect in the memory, including one issued in a refresh read slot, as long as host writes are at least two cycles apart.
- R9: When `disp_en` is low in a cycle, `vfd_blank` is high in the following cycle. Strobe and serial clock timing are unchanged.
- R10: `vfd_sdata` changes only in the cycle where `vfd_sclk` falls or while it is low. It is stable across every high phase of the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_en | input | 1 | Display enable; low forces blank |
| host_we | input | 1 | Host column write strobe, one cycle per write |
| host_addr | input | $clog2(NUM_POS*COLS) | Column address, position*COLS + column |
| host_data | input | ROWS | Column pixels, bit r = row r (row 0 on top) |
| vfd_sclk | output | 1 | Serial shift clock to the driver |
| vfd_sdata | output | 1 | Serial data, valid on the rising edge of vfd_sclk |
| vfd_strobe | output | 1 | Latch strobe, active high |
| vfd_blank | output | 1 | Output blank, active high |

## Verification
The bench builds the block with the full 24 positions of 5x7 dots, DIV = 2 and GAP = 12. GAP = 12 is one cycle above the minimum that fits the five spaced refresh reads. With these values one load is 252 cycles and a full scan is about 6000, so several complete scans fit the run. Each frame is decoded from the serial pins and compared with an arithmetic model. One phase aims host writes exactly at all five refresh slots of 24 successive loads, which drives the hold register through every collision.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  typedef enum logic [1:0] {
    PH_GAP   = 2'd0,
    PH_SHIFT = 2'd1,
    PH_LATCH = 2'd2
  } scan_phase_t;

  // bits per driver load: gate field then anode field
  function automatic int frame_bits(input int npos, input int cols, input int rows);
    return npos + cols * rows;
  endfunction

  // cycles from one strobe rise to the next
  function automatic int load_cycles(input int npos, input int cols, input int rows,
                                     input int gap, input int div);
    return gap + 2 * div * (frame_bits(npos, cols, rows) + 1);
  endfunction

  // memory address of one pixel column
  function automatic int column_addr(input int pos, input int col, input int cols);
    return pos * cols + col;
  endfunction

endpackage

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer
  import vfd_scan_pkg::*;
#(
  parameter int NUM_POS = 24,
  parameter int COLS    = 5,
  parameter int ROWS    = 7,
  parameter int DIV     = 4,
  parameter int GAP     = 16,
  localparam int POS_W  = $clog2(NUM_POS),
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos,
  output logic             fetch_slot,
  output logic             fetch_capture,
  output logic [COL_W-1:0] fetch_col,
  output logic             frame_load,
  output logic             shift_step,
  output logic             latch_next,
  output logic             sclk,
  output logic             strobe
);
  localparam int BITS    = frame_bits(NUM_POS, COLS, ROWS);
  localparam int IDX_MAX = (GAP > BITS) ? GAP : BITS;
  localparam int IDX_W   = $clog2(IDX_MAX + 1);
  localparam int SUB_W   = $clog2(2 * DIV + 1);
  localparam logic [IDX_W-1:0] GAP_LAST  = IDX_W'(GAP - 1);
  localparam logic [IDX_W-1:0] BIT_LAST  = IDX_W'(BITS - 1);
  localparam logic [IDX_W-1:0] FETCH_END = IDX_W'(2 * COLS);
  localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(2 * DIV - 1);
  localparam logic [SUB_W-1:0] SUB_HALF  = SUB_W'(DIV);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(NUM_POS - 1);

  scan_phase_t      phase, nxt_phase;
  logic [IDX_W-1:0] idx, nxt_idx;
  logic [SUB_W-1:0] sub, nxt_sub;
  logic             pos_adv;

  always_comb begin
    nxt_phase = phase;
    nxt_idx   = idx;
    nxt_sub   = sub;
    case (phase)
      PH_GAP: begin
        if (idx == GAP_LAST) begin
          nxt_phase = PH_SHIFT;
          nxt_idx   = '0;
          nxt_sub   = '0;
        end else begin
          nxt_idx = idx + 1'b1;
        end
      end
      PH_SHIFT: begin
        if (sub == SUB_LAST) begin
          nxt_sub = '0;
          if (idx == BIT_LAST) begin
            nxt_phase = PH_LATCH;
            nxt_idx   = '0;
          end else begin
            nxt_idx = idx + 1'b1;
          end
        end else begin
          nxt_sub = sub + 1'b1;
        end
      end
      default: begin
        if (sub == SUB_LAST) begin
          nxt_phase = PH_GAP;
          nxt_sub   = '0;
          nxt_idx   = '0;
        end else begin
          nxt_sub = sub + 1'b1;
        end
      end
    endcase
  end

  // named internal events
  assign pos_adv       = (phase == PH_LATCH) && (sub == SUB_LAST);
  assign fetch_slot    = (phase == PH_GAP) && (idx < FETCH_END) && !idx[0];
  assign fetch_capture = (phase == PH_GAP) && (idx < FETCH_END) && idx[0];
  assign fetch_col     = COL_W'(idx >> 1);
  assign frame_load    = (phase == PH_GAP) && (idx == GAP_LAST);
  assign shift_step    = (phase == PH_SHIFT) && (sub == SUB_LAST);
  assign latch_next    = (nxt_phase == PH_LATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_GAP;
      idx    <= '0;
      sub    <= '0;
      pos    <= '0;
      sclk   <= 1'b0;
      strobe <= 1'b0;
    end else begin
      phase  <= nxt_phase;
      idx    <= nxt_idx;
      sub    <= nxt_sub;
      sclk   <= (nxt_phase == PH_SHIFT) && (nxt_sub >= SUB_HALF);
      strobe <= (nxt_phase == PH_LATCH) && (nxt_sub < SUB_HALF);
      if (pos_adv) pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
    end
  end

  // R2
  sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !sclk);

  // R4
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_adv && pos == POS_LAST) |=> (pos == '0));

endmodule

// File: rtl/vfd_pixel_ram.sv
module vfd_pixel_ram #(
  parameter int DEPTH = 120,
  parameter int W     = 7,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/vfd_host_arb.sv
module vfd_host_arb #(
  parameter int AW = 7,
  parameter int W  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot,
  input  logic [AW-1:0] slot_addr,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [W-1:0]  host_data,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [W-1:0]  ram_wdata
);
  logic          hb_v;
  logic [AW-1:0] hb_addr;
  logic [W-1:0]  hb_data;

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = slot_addr;
    ram_wdata = host_data;
    if (slot) begin
      ram_en = 1'b1;
    end else if (hb_v) begin
      ram_en    = 1'b1;
      ram_we    = 1'b1;
      ram_addr  = hb_addr;
      ram_wdata = hb_data;
    end else if (host_we) begin
      ram_en   = 1'b1;
      ram_we   = 1'b1;
      ram_addr = host_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_v    <= 1'b0;
      hb_addr <= '0;
      hb_data <= '0;
    end else if (slot || hb_v) begin
      // memory busy for this write: park it
      if (host_we) begin
        hb_v    <= 1'b1;
        hb_addr <= host_addr;
        hb_data <= host_data;
      end else if (!slot) begin
        hb_v <= 1'b0;
      end
    end
  end

  // R8
  hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_v && !slot) |=> (!hb_v || $past(host_we)));

endmodule

// File: rtl/vfd_frame_shifter.sv
module vfd_frame_shifter
  import vfd_scan_pkg::*;
#(
  parameter int NUM_POS = 24,
  parameter int COLS    = 5,
  parameter int ROWS    = 7,
  localparam int POS_W  = $clog2(NUM_POS),
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos,
  input  logic             capture,
  input  logic [COL_W-1:0] col,
  input  logic [ROWS-1:0]  rdata,
  input  logic             load,
  input  logic             step,
  output logic             sdata
);
  localparam int BITS = frame_bits(NUM_POS, COLS, ROWS);
  localparam int AN_W = COLS * ROWS;

  logic [AN_W-1:0]    next_anodes;
  logic [NUM_POS-1:0] gate_vec;
  logic [BITS-1:0]    sreg;

  assign gate_vec = NUM_POS'(1) << pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_anodes <= '0;
      sreg        <= '0;
    end else begin
      if (capture) next_anodes[col*ROWS +: ROWS] <= rdata;
      if (load)      sreg <= {next_anodes, gate_vec};
      else if (step) sreg <= {1'b0, sreg[BITS-1:1]};
    end
  end

  assign sdata = sreg[0];

  // R3
  gate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> $onehot(sreg[NUM_POS-1:0]));

endmodule

// File: rtl/vfd_scan_refresh.sv
module vfd_scan_refresh
  import vfd_scan_pkg::*;
#(
  parameter int NUM_POS = 24,
  parameter int COLS    = 5,
  parameter int ROWS    = 7,
  parameter int DIV     = 4,
  parameter int GAP     = 16,
  localparam int AW     = $clog2(NUM_POS * COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_en,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [ROWS-1:0] host_data,
  output logic          vfd_sclk,
  output logic          vfd_sdata,
  output logic          vfd_strobe,
  output logic          vfd_blank
);
  localparam int POS_W = $clog2(NUM_POS);
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int BITS  = frame_bits(NUM_POS, COLS, ROWS);
  localparam int CNT_W = $clog2(BITS + 2);

  logic [POS_W-1:0] pos;
  logic             fetch_slot, fetch_capture, frame_load, shift_step, latch_next;
  logic [COL_W-1:0] fetch_col;
  logic [AW-1:0]    slot_addr;
  logic             ram_en, ram_we;
  logic [AW-1:0]    ram_addr;
  logic [ROWS-1:0]  ram_wdata, ram_rdata;

  vfd_scan_timer #(.NUM_POS(NUM_POS), .COLS(COLS), .ROWS(ROWS), .DIV(DIV), .GAP(GAP)) u_timer (
    .clk(clk), .rst_n(rst_n), .pos(pos),
    .fetch_slot(fetch_slot), .fetch_capture(fetch_capture), .fetch_col(fetch_col),
    .frame_load(frame_load), .shift_step(shift_step), .latch_next(latch_next),
    .sclk(vfd_sclk), .strobe(vfd_strobe)
  );

  assign slot_addr = AW'(column_addr(int'(pos), int'(fetch_col), COLS));

  vfd_host_arb #(.AW(AW), .W(ROWS)) u_arb (
    .clk(clk), .rst_n(rst_n), .slot(fetch_slot), .slot_addr(slot_addr),
    .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  vfd_pixel_ram #(.DEPTH(NUM_POS * COLS), .W(ROWS)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  vfd_frame_shifter #(.NUM_POS(NUM_POS), .COLS(COLS), .ROWS(ROWS)) u_shift (
    .clk(clk), .rst_n(rst_n), .pos(pos), .capture(fetch_capture), .col(fetch_col),
    .rdata(ram_rdata), .load(frame_load), .step(shift_step), .sdata(vfd_sdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vfd_blank <= 1'b1;
    else        vfd_blank <= latch_next | ~disp_en;
  end

  // checker state: serial clock edges counted per load
  logic             sclk_d, strobe_d;
  logic [CNT_W-1:0] rise_cnt;
  logic             sclk_rise, strobe_rise;

  assign sclk_rise   = vfd_sclk & ~sclk_d;
  assign strobe_rise = vfd_strobe & ~strobe_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      strobe_d <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d   <= vfd_sclk;
      strobe_d <= vfd_strobe;
      if (strobe_rise)    rise_cnt <= '0;
      else if (sclk_rise) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R2
  sclk_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |-> (rise_cnt == CNT_W'(BITS)));

  // R6
  strobe_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vfd_strobe |-> vfd_blank);

  // R9
  disabled_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(disp_en) |-> vfd_blank);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vfd_sclk && sclk_d) |-> $stable(vfd_sdata));

endmodule

// File: tb/vfd_scan_refresh_test.sv
module vfd_scan_refresh_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPOS   = 24;
  localparam int COLS   = 5;
  localparam int ROWS   = 7;
  localparam int DIV    = 2;
  localparam int GAP    = 12;
  localparam int BITS   = NPOS + COLS * ROWS;
  localparam int PERIOD = GAP + 2 * DIV * (BITS + 1);
  localparam int DEPTH  = NPOS * COLS;
  localparam int AW     = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_en = 1'b1;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [ROWS-1:0] host_data = '0;
  logic vfd_sclk, vfd_sdata, vfd_strobe, vfd_blank;

  vfd_scan_refresh #(.NUM_POS(NPOS), .COLS(COLS), .ROWS(ROWS), .DIV(DIV), .GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .host_we(host_we),
    .host_addr(host_addr), .host_data(host_data),
    .vfd_sclk(vfd_sclk), .vfd_sdata(vfd_sdata), .vfd_strobe(vfd_strobe), .vfd_blank(vfd_blank)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ROWS-1:0] pat(input int a, input int seed);
    return ROWS'((a * 29 + seed * 53 + (a >> 2) * seed) ^ (seed * 3));
  endfunction

  logic [ROWS-1:0] model [DEPTH];
  bit    content_ok = 0;
  string ctag = "R5";

  // serial decoder and per-cycle checks
  logic [BITS-1:0] frame;
  int  bitn = 0, exp_pos = 0, cyc = 0, last_stb = 0, since_stb = 0, stb_w = 0;
  bit  seen_stb = 0;
  logic sclk_p = 0, stb_p = 0, sdata_p = 0, en_p = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (vfd_sclk && sclk_p)
        check(vfd_sdata == sdata_p, "R10", vfd_sdata, sdata_p);
      if (vfd_sclk && !sclk_p) begin
        if (bitn < BITS) frame[bitn] = vfd_sdata;
        bitn++;
      end
      if (vfd_strobe) stb_w++;
      if (!vfd_strobe && stb_p) begin
        check(stb_w == DIV, "R6", stb_w, DIV);
        stb_w = 0;
      end
      if (vfd_strobe && !stb_p) begin
        logic [COLS*ROWS-1:0] exp_an;
        int ones;
        check(bitn == BITS, "R2", bitn, BITS);
        check(!vfd_sclk, "R2", vfd_sclk, 0);
        ones = $countones(frame[NPOS-1:0]);
        check(ones == 1, "R3", ones, 1);
        check(frame[exp_pos] == 1'b1, "R4", frame[NPOS-1:0], longint'(1) << exp_pos);
        if (content_ok) begin
          for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
              exp_an[c*ROWS+r] = model[exp_pos*COLS+c][r];
          check(frame[BITS-1:NPOS] == exp_an, ctag, frame[BITS-1:NPOS], exp_an);
        end
        if (seen_stb) check(cyc - last_stb == PERIOD, "R7", cyc - last_stb, PERIOD);
        last_stb  = cyc;
        seen_stb  = 1;
        since_stb = 0;
        bitn      = 0;
        exp_pos   = (exp_pos + 1) % NPOS;
      end else begin
        since_stb++;
      end
      if (seen_stb) begin
        bit exp_b;
        exp_b = (since_stb < 2 * DIV) || !en_p;
        check(vfd_blank == exp_b, en_p ? "R6" : "R9", vfd_blank, exp_b);
      end
      sclk_p  = vfd_sclk;
      stb_p   = vfd_strobe;
      sdata_p = vfd_sdata;
    end
    en_p = disp_en;
  end

  task automatic wr(input int a, input logic [ROWS-1:0] d);
    host_we = 1'b1; host_addr = AW'(a); host_data = d;
    @(posedge clk); #1;
    host_we = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(vfd_sclk == 0,   "R1", vfd_sclk, 0);
    check(vfd_strobe == 0, "R1", vfd_strobe, 0);
    check(vfd_sdata == 0,  "R1", vfd_sdata, 0);
    check(vfd_blank == 1,  "R1", vfd_blank, 1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // heavy back-to-back traffic, then final values at odd spacing (R5, R7)
    for (int k = 0; k < 600; k++) wr(k % DEPTH, pat(k, 7));
    for (int a = 0; a < DEPTH; a++) begin
      wr(a, pat(a, 1));
      model[a] = pat(a, 1);
      repeat (3) @(posedge clk);
      #1;
    end
    repeat (25 * PERIOD) @(posedge clk);
    content_ok = 1;
    repeat (2 * NPOS * PERIOD) @(posedge clk);

    // R8: writes aimed at each refresh read slot of 24 loads
    content_ok = 0;
    ctag = "R8";
    for (int m = 0; m < NPOS; m++) begin
      @(posedge vfd_strobe);
      repeat (2 * DIV) @(posedge clk);
      #1;
      for (int c = 0; c < COLS; c++) begin
        wr(m * COLS + c, pat(m * COLS + c, 2));
        model[m*COLS+c] = pat(m * COLS + c, 2);
      end
    end
    repeat (25 * PERIOD) @(posedge clk);
    content_ok = 1;
    repeat (2 * NPOS * PERIOD) @(posedge clk);

    // R9: display disabled for three loads, timing keeps running
    #1;
    disp_en = 1'b0;
    repeat (3 * PERIOD) @(posedge clk);
    #1;
    disp_en = 1'b1;
    repeat (2 * PERIOD) @(posedge clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule